// File: doc/BRIEF.md
# Selectable-Topology Parallel Prefix Adder

This block is a purely combinational adder of `WIDTH` bits, where `WIDTH` is a power of two and at least 8. It adds two operands and a carry input, and returns the sum together with a carry output. It is the addition core that a multiply-accumulate datapath would use both for partial-product reduction and for the accumulation step.

The addition is split into three parts:

- A bitwise stage forms generate and propagate flags for each bit.
- A logarithmic prefix network of group cells turns these flags into one carry per bit position.
- A final exclusive-OR stage produces the sum bits.

The carry input is merged into bit 0 ahead of the network, so it behaves as a generate signal one position below the least significant bit.

An elaboration parameter picks the shape of the prefix network. The choices trade logic depth against cell count:

- **Dense:** one combine per bit per level.
- **Sparse:** an up-sweep tree followed by a down-sweep tree.
- **Odd-bit dense:** a dense core on odd bits only, with a final fix-up level.
- **Quarter-bit dense:** a dense core on every fourth bit, wrapped in sparse levels.

Two constant outputs report how many prefix levels and how many group cells the chosen network contains, so the integrator can check them.

Top module: `prefix_adder`

## Requirements
- R1: For any operands and carry input, `{carryOut, sum}` equals `opA + opB + carryIn` computed to `WIDTH+1` bits.
- R2: A carry input of 1 enters at bit 0. With `opA` all ones, `opB` zero and `carryIn` 1, the sum is zero and `carryOut` is 1. With `carryIn` 0 the sum is all ones and `carryOut` is 0.
- R3: All-ones plus all-ones gives a sum of all ones except bit 0, which equals `carryIn`, and `carryOut` is 1.
- R4: With both operands zero, the sum equals `carryIn` in bit 0 and zero elsewhere, and `carryOut` is 0.
- R5: The alternating patterns 0x5555 and 0xAAAA (in either order) give a sum of all ones and `carryOut` 0 when `carryIn` is 0. They give a sum of zero and `carryOut` 1 when `carryIn` is 1.
- R6: `TOPO` takes these values: 0 dense, 1 sparse, 2 odd-bit dense, 3 quarter-bit dense. All four produce identical outputs for identical inputs.
- R7: `levelCount` equals the number of prefix levels. With L = log2 WIDTH, this is L for dense, 2(L-1) for sparse, L+1 for odd-bit dense and L+2 for quarter-bit dense.
- R8: `cellTotal` equals the number of group cells in the network. This is 1 + WIDTH·L − WIDTH for dense, 2(WIDTH−1) − L for sparse, (WIDTH/2)·L for odd-bit dense and (WIDTH/4)·L + 3·WIDTH/4 − 1 for quarter-bit dense. The carry-input merge is not counted.
- R9: `carryOut` is the group generate over all bits. A carry generated in the top bit alone (0x8000 + 0x8000) gives `carryOut` 1 and a sum of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| carryOut | output | 1 | Carry out of the top bit |
| cellTotal | output | 16 | Constant: group cells in the selected network |
| levelCount | output | 8 | Constant: prefix levels in the selected network |

## Verification
Two functions can fall on the same input vector: the carry input entering at bit 0, and a propagate chain that runs the full width up to the carry output. The bench provokes this overlap in two ways. It applies all-propagate operands (all ones plus zero, and the two alternating patterns) with the carry input toggled between applications. It also applies all-ones plus all-ones, where generation and the carry input act on the same bits. Each result is judged against a wide integer sum formed in the bench, separately for all four network shapes. The bench also compares the reported level and cell counts against the closed-form expressions for a width of 16.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  typedef enum int {
    TOPO_DENSE   = 0,
    TOPO_SPARSE  = 1,
    TOPO_ODDCORE = 2,
    TOPO_QUADCORE = 3
  } topo_e;

  // number of prefix levels the network is built with
  function automatic int treeDepth(topo_e topo, int lg);
    case (topo)
      TOPO_DENSE:    return lg;
      TOPO_SPARSE:   return 2 * lg - 2;
      TOPO_ODDCORE:  return lg + 1;
      default:       return lg + 2;
    endcase
  endfunction

  // source bit of the cell at (lv, i), or -1 when the bit passes through
  function automatic int cellSrc(topo_e topo, int lg, int lv, int i);
    int d;
    int s;
    int dd;
    case (topo)
      TOPO_DENSE: begin
        d = 1 << (lv - 1);
        if (i >= d) return i - d;
      end
      TOPO_SPARSE: begin
        if (lv <= lg) begin
          d = 1 << lv;
          if (((i + 1) % d) == 0) return i - d / 2;
        end
        if (lv >= lg) begin
          dd = lv - lg + 1;
          if (dd <= lg - 1) begin
            s = 1 << (lg - 1 - dd);
            if (i >= 2 * s && ((i + 1) % (2 * s)) == s) return i - s;
          end
        end
      end
      TOPO_ODDCORE: begin
        if (lv == 1) begin
          if ((i % 2) == 1) return i - 1;
        end else if (lv <= lg) begin
          d = 1 << (lv - 1);
          if ((i % 2) == 1 && i >= d + 1) return i - d;
        end else begin
          if ((i % 2) == 0 && i >= 2) return i - 1;
        end
      end
      default: begin
        if (lv == 1) begin
          if ((i % 2) == 1) return i - 1;
        end else if (lv == 2) begin
          if ((i % 4) == 3) return i - 2;
        end else if (lv <= lg) begin
          d = 1 << (lv - 1);
          if ((i % 4) == 3 && i >= d + 3) return i - d;
        end else if (lv == lg + 1) begin
          if ((i % 4) == 1 && i >= 5) return i - 2;
        end else begin
          if ((i % 2) == 0 && i >= 2) return i - 1;
        end
      end
    endcase
    return -1;
  endfunction

  // a cell is grey when its result group already reaches bit 0
  function automatic bit cellGrey(topo_e topo, int lg, int lv, int i);
    case (topo)
      TOPO_DENSE: return i < (1 << lv);
      TOPO_SPARSE: begin
        if (lv <= lg && ((i + 1) % (1 << lv)) == 0) return (i + 1) == (1 << lv);
        return 1'b1;
      end
      TOPO_ODDCORE: begin
        if (lv == 1) return i == 1;
        if (lv <= lg) return (i + 1) <= (1 << lv);
        return 1'b1;
      end
      default: begin
        if (lv == 1) return i == 1;
        if (lv == 2) return i == 3;
        if (lv <= lg) return (i + 1) <= (1 << lv);
        return 1'b1;
      end
    endcase
  endfunction

  function automatic int cellCount(topo_e topo, int lg);
    int n;
    n = 0;
    for (int lv = 1; lv <= treeDepth(topo, lg); lv++)
      for (int i = 0; i < (1 << lg); i++)
        if (cellSrc(topo, lg, lv, i) >= 0) n++;
    return n;
  endfunction

  function automatic int levelsUsed(topo_e topo, int lg);
    int n;
    bit any;
    n = 0;
    for (int lv = 1; lv <= treeDepth(topo, lg); lv++) begin
      any = 1'b0;
      for (int i = 0; i < (1 << lg); i++)
        if (cellSrc(topo, lg, lv, i) >= 0) any = 1'b1;
      if (any) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/ppa_pregen.sv
module ppa_pregen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] genBit,
  output logic [WIDTH-1:0] propBit
);

  assign genBit  = opA & opB;
  assign propBit = opA ^ opB;

  // R1
  always_comb begin
    gen_prop_excl_chk: assert ((genBit & propBit) == '0);
  end

endmodule

// File: rtl/ppa_tree.sv
module ppa_tree #(
  parameter int           WIDTH = 16,
  parameter ppa_pkg::topo_e TOPO = ppa_pkg::TOPO_DENSE
) (
  input  logic [WIDTH-1:0] genIn,
  input  logic [WIDTH-1:0] propIn,
  input  logic             carryIn,
  output logic [WIDTH-1:0] carryVec
);

  localparam int LOG2W = $clog2(WIDTH);
  localparam int DEPTH = ppa_pkg::treeDepth(TOPO, LOG2W);

  logic [DEPTH:0][WIDTH-1:0] gLev;
  logic [DEPTH:0][WIDTH-1:0] pLev;

  // carry input treated as generate one position below bit 0
  assign gLev[0][0]         = genIn[0] | (propIn[0] & carryIn);
  assign pLev[0][0]         = 1'b0;
  assign gLev[0][WIDTH-1:1] = genIn[WIDTH-1:1];
  assign pLev[0][WIDTH-1:1] = propIn[WIDTH-1:1];

  for (genvar lv = 1; lv <= DEPTH; lv++) begin : g_level
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam int SRC  = ppa_pkg::cellSrc(TOPO, LOG2W, lv, i);
      localparam bit GREY = ppa_pkg::cellGrey(TOPO, LOG2W, lv, i);
      if (SRC < 0) begin : g_pass
        assign gLev[lv][i] = gLev[lv-1][i];
        assign pLev[lv][i] = pLev[lv-1][i];
      end else if (GREY) begin : g_grey
        assign gLev[lv][i] = gLev[lv-1][i] | (pLev[lv-1][i] & gLev[lv-1][SRC]);
        assign pLev[lv][i] = 1'b0;
      end else begin : g_black
        assign gLev[lv][i] = gLev[lv-1][i] | (pLev[lv-1][i] & gLev[lv-1][SRC]);
        assign pLev[lv][i] = pLev[lv-1][i] & pLev[lv-1][SRC];
      end
    end
  end

  assign carryVec = gLev[DEPTH];

  // R1
  always_comb begin
    for (int lv = 0; lv <= DEPTH; lv++) begin
      group_excl_chk: assert ((gLev[lv] & pLev[lv]) == '0);
    end
  end

  // R9
  always_comb begin
    gen_sets_carry_chk: assert ((genIn & ~carryVec) == '0);
  end

  // R4
  always_comb begin
    kill_clears_carry_chk: assert ((~genIn & ~propIn & carryVec) == '0);
  end

endmodule

// File: rtl/ppa_post.sv
module ppa_post #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] propIn,
  input  logic [WIDTH-1:0] carryVec,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);

  assign sum      = propIn ^ {carryVec[WIDTH-2:0], carryIn};
  assign carryOut = carryVec[WIDTH-1];

endmodule

// File: rtl/prefix_adder.sv
module prefix_adder #(
  parameter int             WIDTH = 16,
  parameter ppa_pkg::topo_e TOPO  = ppa_pkg::TOPO_DENSE
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic [15:0]      cellTotal,
  output logic [7:0]       levelCount
);

  localparam int LOG2W  = $clog2(WIDTH);
  localparam int CELLS  = ppa_pkg::cellCount(TOPO, LOG2W);
  localparam int LEVELS = ppa_pkg::levelsUsed(TOPO, LOG2W);

  logic [WIDTH-1:0] genBit;
  logic [WIDTH-1:0] propBit;
  logic [WIDTH-1:0] carryVec;

  ppa_pregen #(.WIDTH(WIDTH)) u_pre (
    .opA     (opA),
    .opB     (opB),
    .genBit  (genBit),
    .propBit (propBit)
  );

  ppa_tree #(.WIDTH(WIDTH), .TOPO(TOPO)) u_tree (
    .genIn    (genBit),
    .propIn   (propBit),
    .carryIn  (carryIn),
    .carryVec (carryVec)
  );

  ppa_post #(.WIDTH(WIDTH)) u_post (
    .propIn   (propBit),
    .carryVec (carryVec),
    .carryIn  (carryIn),
    .sum      (sum),
    .carryOut (carryOut)
  );

  assign cellTotal  = 16'(CELLS);
  assign levelCount = 8'(LEVELS);

  // R1
  always_comb begin
    sum_match_chk: assert ({carryOut, sum} ==
      ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}));
  end

  // R2
  always_comb begin
    if (&(opA ^ opB)) begin
      full_prop_cout_chk: assert (carryOut == carryIn);
    end
  end

endmodule

// File: tb/tb_prefix_adder.sv
module tb_prefix_adder;

  localparam int W  = 16;
  localparam int LG = 4;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         cin = 1'b0;

  logic [W-1:0] sumO  [NT];
  logic         coutO [NT];
  logic [15:0]  cellO [NT];
  logic [7:0]   lvlO  [NT];

  for (genvar t = 0; t < NT; t++) begin : g_topo
    prefix_adder #(.WIDTH(W), .TOPO(ppa_pkg::topo_e'(t))) dut (
      .opA        (opA),
      .opB        (opB),
      .carryIn    (cin),
      .sum        (sumO[t]),
      .carryOut   (coutO[t]),
      .cellTotal  (cellO[t]),
      .levelCount (lvlO[t])
    );
  end

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  task automatic applyVec(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic c, input string tag);
    logic [W:0] exp;
    opA = a;
    opB = b;
    cin = c;
    @(negedge clk);
    exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    for (int t = 0; t < NT; t++) begin
      nChecks++;
      if ({coutO[t], sumO[t]} !== exp) begin
        nFail++;
        $display("FAIL %s topo %0d a=%h b=%h cin=%0d: got %h expected %h",
                 tag, t, a, b, c, {coutO[t], sumO[t]}, exp);
      end
    end
  endtask

  // R7 and R8: reported structure against closed forms
  task automatic testStructure();
    int expCells [NT];
    int expLvls  [NT];
    expCells[0] = 1 + W * LG - W;     expLvls[0] = LG;
    expCells[1] = 2 * (W - 1) - LG;   expLvls[1] = 2 * (LG - 1);
    expCells[2] = (W / 2) * LG;       expLvls[2] = LG + 1;
    expCells[3] = (W / 4) * LG + (3 * W) / 4 - 1; expLvls[3] = LG + 2;
    @(negedge clk);
    for (int t = 0; t < NT; t++) begin
      nChecks++;
      if (int'(lvlO[t]) != expLvls[t]) begin
        nFail++;
        $display("FAIL R7 topo %0d depth: got %0d expected %0d", t, lvlO[t], expLvls[t]);
      end
      nChecks++;
      if (int'(cellO[t]) != expCells[t]) begin
        nFail++;
        $display("FAIL R8 topo %0d cells: got %0d expected %0d", t, cellO[t], expCells[t]);
      end
    end
  endtask

  // R4: zero operands
  task automatic testZero();
    applyVec('0, '0, 1'b0, "R4");
    applyVec('0, '0, 1'b1, "R4");
  endtask

  // R2: carry input rippling the whole width
  task automatic testCarryIn();
    applyVec('1, '0, 1'b1, "R2");
    applyVec('1, '0, 1'b0, "R2");
    applyVec('0, '1, 1'b1, "R2");
    applyVec('1, 16'h0001, 1'b0, "R2");
  endtask

  // R3: all ones plus all ones
  task automatic testAllOnes();
    applyVec('1, '1, 1'b0, "R3");
    applyVec('1, '1, 1'b1, "R3");
  endtask

  // R5: alternating patterns
  task automatic testAlternate();
    applyVec(16'h5555, 16'hAAAA, 1'b0, "R5");
    applyVec(16'h5555, 16'hAAAA, 1'b1, "R5");
    applyVec(16'hAAAA, 16'h5555, 1'b1, "R5");
    applyVec(16'hAAAA, 16'hAAAA, 1'b0, "R5");
  endtask

  // R9: carry generated only in the top bit
  task automatic testTopCarry();
    applyVec(16'h8000, 16'h8000, 1'b0, "R9");
    applyVec(16'h8000, 16'h7FFF, 1'b1, "R9");
  endtask

  // R1: random operands
  task automatic testRandom(input int n);
    for (int k = 0; k < n; k++)
      applyVec(W'($urandom), W'($urandom), 1'($urandom), "R1");
  endtask

  // R6: all topologies agree with each other
  task automatic testAgree(input int n);
    for (int k = 0; k < n; k++) begin
      opA = W'($urandom);
      opB = W'($urandom);
      cin = 1'($urandom);
      @(negedge clk);
      for (int t = 1; t < NT; t++) begin
        nChecks++;
        if ({coutO[t], sumO[t]} !== {coutO[0], sumO[0]}) begin
          nFail++;
          $display("FAIL R6 topo %0d: got %h expected %h", t,
                   {coutO[t], sumO[t]}, {coutO[0], sumO[0]});
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testStructure();
    testZero();
    testCarryIn();
    testAllOnes();
    testAlternate();
    testTopCarry();
    testRandom(1500);
    testAgree(500);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule